// File: doc/BRIEF.md
# Strided Column Transpose Buffer

This block sits between the 7-point and 9-point transform stages of a 1008-point prime-factor FFT. The 7-point stage delivers its results in row order, eight samples per clock. The 9-point stage needs each of its inputs gathered from samples seven addresses apart. The block writes each incoming frame linearly into one half of a double buffer. It reads the other half back as 9-sample columns, one column per clock. Consecutive columns leave on two output streams in turn.

Storage is split into eight banks selected by the low three address bits. A stride of seven lands eight consecutive column elements in eight different banks. The ninth element collides with the first, so it is served by a second read port on each bank. A full frame is 126 input beats and 112 output groups. Group g reads base address 63*(g/7) + g%7, plus 7*r for element r. Groups walk the seven positions inside a 63-sample plane first, then step to the next plane.

Top module: `colxpose_top`

## Requirements
- R1: Out of reset, in_ready is 1 and neither out0_valid nor out1_valid is asserted.
- R2: Input lane j of accepted beat k (bits j*16 and up, 16-bit samples) is frame sample 8k+j. Output element r of a group (bits r*16 and up) is frame sample base + 7r, with base = 63*(g/7) + g%7.
- R3: Within a frame, groups leave in order g = 0..111. Frames leave in the order they were written.
- R4: The n-th group since reset (counting from 0) appears only on stream n mod 2 (0 = out0, 1 = out1). The two valids are never high together.
- R5: With both outputs ready and input offered every cycle, the first output valid is seen exactly 128 clock edges after the edge that accepts the first input beat.
- R6: While a stream holds valid high and its ready is low, its valid and data stay unchanged on the next cycle.
- R7: When one half holds a complete frame and the other half is still waiting to drain, in_ready is low. A beat offered then is not taken and does not appear in any output.
- R8: With outputs always ready, back-to-back frames are accepted with in_ready held high on every beat, because a half drains before the writer returns to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | 128 | Eight row-ordered 16-bit samples, lane 0 lowest |
| out0_valid | output | 1 | Group present on stream 0 |
| out0_ready | input | 1 | Stream 0 consumer accepts |
| out0_data | output | 144 | Nine 16-bit column samples, element 0 lowest |
| out1_valid | output | 1 | Group present on stream 1 |
| out1_ready | input | 1 | Stream 1 consumer accepts |
| out1_data | output | 144 | Nine 16-bit column samples, element 0 lowest |

## Verification
Every sample carries its own running index, so any misrouted bank, wrong stride or skipped group shows up as a wrong value at a known element position. Free-running single and triple frames measure the fixed latency and confirm that the double buffer overlaps without input stalls. A run with input gaps and uneven ready patterns on the two streams separates correct stall freezing from pointers that slip. A run that holds both outputs blocked fills both halves and offers a marked beat against a low in_ready. The frame sent after that run proves the marked beat was never written.

// File: rtl/colxpose_pkg.sv
package colxpose_pkg;
  localparam int unsigned CX_WIDTH  = 16;
  localparam int unsigned CX_LANES  = 8;
  localparam int unsigned CX_STRIDE = 7;
  localparam int unsigned CX_GROUP  = 9;
  localparam int unsigned CX_FRAME  = 1008;

  typedef enum logic {
    STRM_0 = 1'b0,
    STRM_1 = 1'b1
  } strm_e;
endpackage

// File: rtl/colxpose_bank.sv
module colxpose_bank #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/colxpose_rdaddr.sv
module colxpose_rdaddr #(
  parameter int unsigned FRAME  = 1008,
  parameter int unsigned STRIDE = 7,
  parameter int unsigned GROUP  = 9,
  parameter int unsigned LANES  = 8,
  localparam int unsigned AW    = $clog2(FRAME),
  localparam int unsigned BW    = $clog2(LANES),
  localparam int unsigned RWH   = AW - BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  output logic           last,
  output logic [BW-1:0]  bank_of [GROUP],
  output logic [RWH-1:0] row_of  [GROUP]
);
  localparam int unsigned PLANE     = STRIDE * GROUP;
  localparam int unsigned LAST_BASE = FRAME - STRIDE * (GROUP - 1) - 1;
  localparam int unsigned NW        = $clog2(STRIDE);

  logic [AW-1:0] base_q, base_d;
  logic [NW-1:0] pos_q, pos_d;

  assign last = (base_q == AW'(LAST_BASE));

  always_comb begin
    base_d = base_q;
    pos_d  = pos_q;
    if (step) begin
      if (last) begin
        base_d = '0;
        pos_d  = '0;
      end else if (pos_q == NW'(STRIDE - 1)) begin
        base_d = base_q + AW'(PLANE - STRIDE + 1);
        pos_d  = '0;
      end else begin
        base_d = base_q + AW'(1);
        pos_d  = pos_q + NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pos_q  <= '0;
    end else begin
      base_q <= base_d;
      pos_q  <= pos_d;
    end
  end

  for (genvar r = 0; r < GROUP; r++) begin : g_elem
    logic [AW-1:0] addr;
    assign addr       = base_q + AW'(STRIDE * r);
    assign bank_of[r] = addr[BW-1:0];
    assign row_of[r]  = addr[AW-1:BW];
  end

  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(base_q) + STRIDE * (GROUP - 1)) < FRAME);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (base_q == '0));
endmodule

// File: rtl/colxpose_pingpong.sv
module colxpose_pingpong #(
  parameter int unsigned ROWS = 126,
  parameter int unsigned RW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          rd_fire,
  input  logic          rd_last,
  output logic          in_ready,
  output logic          wr_en,
  output logic [RW-1:0] wr_row,
  output logic          wr_half,
  output logic          rd_active,
  output logic          rd_half
);
  logic [1:0]    loaded_q, loaded_d;
  logic [RW-1:0] wr_row_q, wr_row_d;
  logic          wr_half_q, wr_half_d;
  logic          rd_half_q, rd_half_d;
  logic          rd_act_q, rd_act_d;
  logic          wr_end, rd_end;

  always_comb begin
    in_ready  = !loaded_q[wr_half_q];
    wr_en     = in_valid && in_ready;
    wr_end    = wr_en && (wr_row_q == RW'(ROWS - 1));
    rd_end    = rd_fire && rd_last;
    loaded_d  = loaded_q;
    wr_row_d  = wr_row_q;
    wr_half_d = wr_half_q;
    rd_half_d = rd_half_q;
    rd_act_d  = rd_act_q;
    if (wr_en) begin
      wr_row_d = wr_end ? '0 : wr_row_q + RW'(1);
    end
    if (wr_end) begin
      loaded_d[wr_half_q] = 1'b1;
      wr_half_d           = ~wr_half_q;
    end
    if (rd_end) begin
      loaded_d[rd_half_q] = 1'b0;
      rd_half_d           = ~rd_half_q;
      rd_act_d            = 1'b0;
    end else if (!rd_act_q) begin
      rd_act_d = loaded_q[rd_half_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q  <= '0;
      wr_row_q  <= '0;
      wr_half_q <= 1'b0;
      rd_half_q <= 1'b0;
      rd_act_q  <= 1'b0;
    end else begin
      loaded_q  <= loaded_d;
      wr_row_q  <= wr_row_d;
      wr_half_q <= wr_half_d;
      rd_half_q <= rd_half_d;
      rd_act_q  <= rd_act_d;
    end
  end

  assign wr_row    = wr_row_q;
  assign wr_half   = wr_half_q;
  assign rd_half   = rd_half_q;
  assign rd_active = rd_act_q;

  assert_write_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_act_q) |-> (wr_half_q != rd_half_q));

  assert_read_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act_q |-> loaded_q[rd_half_q]);
endmodule

// File: rtl/colxpose_top.sv
module colxpose_top
  import colxpose_pkg::*;
#(
  parameter int unsigned W      = CX_WIDTH,
  parameter int unsigned LANES  = CX_LANES,
  parameter int unsigned STRIDE = CX_STRIDE,
  parameter int unsigned GROUP  = CX_GROUP,
  parameter int unsigned FRAME  = CX_FRAME
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LANES*W-1:0]   in_data,
  output logic                 out0_valid,
  input  logic                 out0_ready,
  output logic [GROUP*W-1:0]   out0_data,
  output logic                 out1_valid,
  input  logic                 out1_ready,
  output logic [GROUP*W-1:0]   out1_data
);
  localparam int unsigned ROWS = FRAME / LANES;
  localparam int unsigned AW   = $clog2(FRAME);
  localparam int unsigned BW   = $clog2(LANES);
  localparam int unsigned RWH  = AW - BW;
  localparam int unsigned BAW  = RWH + 1;

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  logic           wr_en, wr_half, rd_active, rd_half, rd_last, rd_fire, advance;
  logic [RWH-1:0] wr_row;
  logic [BW-1:0]  bank_of [GROUP];
  logic [RWH-1:0] row_of  [GROUP];
  logic [BAW-1:0] ra0 [LANES];
  logic [BAW-1:0] ra1 [LANES];
  logic [W-1:0]   rd0 [LANES];
  logic [W-1:0]   rd1 [LANES];
  logic [GROUP*W-1:0] xbar, s1_data, o_data;
  logic           s1_vld, o_vld;
  strm_e          s1_sel, o_sel, grp_sel_q, grp_sel_d;

  colxpose_pingpong #(.ROWS(ROWS), .RW(RWH)) u_pp (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .rd_fire(rd_fire),
    .rd_last(rd_last), .in_ready(in_ready), .wr_en(wr_en), .wr_row(wr_row),
    .wr_half(wr_half), .rd_active(rd_active), .rd_half(rd_half)
  );

  colxpose_rdaddr #(.FRAME(FRAME), .STRIDE(STRIDE), .GROUP(GROUP), .LANES(LANES)) u_ra (
    .clk(clk), .rst_n(rst_sync_n), .step(rd_fire), .last(rd_last),
    .bank_of(bank_of), .row_of(row_of)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    colxpose_bank #(.W(W), .AW(BAW)) u_bank (
      .clk(clk), .we(wr_en), .waddr({wr_half, wr_row}),
      .wdata(in_data[b*W +: W]), .ra0(ra0[b]), .ra1(ra1[b]),
      .rd0(rd0[b]), .rd1(rd1[b])
    );

    logic [LANES-1:0] hit;
    for (genvar r = 0; r < LANES; r++) begin : g_hit
      assign hit[r] = (bank_of[r] == BW'(b));
    end

    assert_bank_unique_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      rd_active |-> ($countones(hit) == 1));
  end

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      ra0[b] = '0;
      ra1[b] = '0;
      for (int r = 0; r < GROUP; r++) begin
        if (bank_of[r] == BW'(b)) begin
          if (r < LANES) ra0[b] = {rd_half, row_of[r]};
          else           ra1[b] = {rd_half, row_of[r]};
        end
      end
    end
    for (int r = 0; r < GROUP; r++) begin
      xbar[r*W +: W] = (r < LANES) ? rd0[bank_of[r]] : rd1[bank_of[r]];
    end
  end

  always_comb begin
    advance   = !o_vld || ((o_sel == STRM_1) ? out1_ready : out0_ready);
    rd_fire   = rd_active && advance;
    grp_sel_d = grp_sel_q;
    if (rd_fire) begin
      grp_sel_d = (grp_sel_q == STRM_0) ? STRM_1 : STRM_0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld    <= 1'b0;
      s1_sel    <= STRM_0;
      o_vld     <= 1'b0;
      o_sel     <= STRM_0;
      grp_sel_q <= STRM_0;
    end else begin
      grp_sel_q <= grp_sel_d;
      if (advance) begin
        s1_vld <= rd_fire;
        s1_sel <= grp_sel_q;
        o_vld  <= s1_vld;
        o_sel  <= s1_sel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      s1_data <= xbar;
      o_data  <= s1_data;
    end
  end

  assign out0_valid = o_vld && (o_sel == STRM_0);
  assign out1_valid = o_vld && (o_sel == STRM_1);
  assign out0_data  = o_data;
  assign out1_data  = o_data;

  assert_one_stream_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(out0_valid && out1_valid));

  assert_hold0_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out0_valid && !out0_ready) |=> (out0_valid && $stable(out0_data)));

  assert_hold1_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out1_valid && !out1_ready) |=> (out1_valid && $stable(out1_data)));
endmodule

// File: tb/sim_colxpose_top.sv
module sim_colxpose_top;
  localparam int W   = 16;
  localparam int L   = 8;
  localparam int G   = 9;
  localparam int FR  = 1008;
  localparam int GPF = 112;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready;
  logic [L*W-1:0] in_data;
  logic out0_valid, out0_ready, out1_valid, out1_ready;
  logic [G*W-1:0] out0_data, out1_data;

  always #2 clk = ~clk;

  colxpose_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out0_valid(out0_valid), .out0_ready(out0_ready),
    .out0_data(out0_data), .out1_valid(out1_valid), .out1_ready(out1_ready),
    .out1_data(out1_data)
  );

  int checks = 0, errors = 0, cyc = 0, beats = 0, grps = 0, rmode = 0;
  int first_acc = -1, first_out = -1;
  bit arm_lat = 0, pstall0 = 0, pstall1 = 0;
  logic [G*W-1:0] pdata0, pdata1;

  task automatic chk(bit ok, string tag, logic [G*W-1:0] act, logic [G*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [G*W-1:0] exp_grp(int n);
    int f, g, base;
    logic [G*W-1:0] v;
    f = n / GPF;
    g = n % GPF;
    base = 63 * (g / 7) + g % 7;
    for (int r = 0; r < G; r++) v[r*W +: W] = 16'(f * FR + base + 7 * r);
    return v;
  endfunction

  function automatic logic [L*W-1:0] beat_vec(int b);
    logic [L*W-1:0] v;
    for (int j = 0; j < L; j++) v[j*W +: W] = 16'(b * L + j);
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    case (rmode)
      0: begin out0_ready = 1'b1; out1_ready = 1'b1; end
      1: begin out0_ready = (cyc % 3) != 0; out1_ready = (cyc % 5) != 1; end
      default: begin out0_ready = 1'b0; out1_ready = 1'b0; end
    endcase
  end

  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1) begin
      if (out0_valid && out1_valid) chk(0, "R4 both streams valid", 1, 0);
      if (pstall0) chk(out0_valid && out0_data == pdata0, "R6 stream0 hold", out0_data, pdata0);
      if (pstall1) chk(out1_valid && out1_data == pdata1, "R6 stream1 hold", out1_data, pdata1);
      if (arm_lat && first_out < 0 && (out0_valid || out1_valid)) first_out = cyc;
      if (out0_valid && out0_ready) begin
        chk(grps % 2 == 0, "R4 group on stream0", 0, G*W'(grps % 2));
        chk(out0_data == exp_grp(grps), "R2 R3 stream0 group content", out0_data, exp_grp(grps));
        grps++;
      end
      if (out1_valid && out1_ready) begin
        chk(grps % 2 == 1, "R4 group on stream1", 1, G*W'(grps % 2));
        chk(out1_data == exp_grp(grps), "R2 R3 stream1 group content", out1_data, exp_grp(grps));
        grps++;
      end
      pstall0 = out0_valid && !out0_ready;
      pstall1 = out1_valid && !out1_ready;
      pdata0  = out0_data;
      pdata1  = out1_data;
    end
  end

  task automatic send_beats(int n, bit gaps, bit need_rdy);
    for (int i = 0; i < n; i++) begin
      bit done = 0;
      while (!done) begin
        @(negedge clk);
        in_valid = !gaps || (cyc % 4 != 3);
        in_data  = beat_vec(beats);
        #1;
        if (need_rdy) chk(in_ready, "R8 in_ready high in continuous flow", G*W'(in_ready), 1);
        if (in_valid && in_ready) begin
          if (arm_lat && first_acc < 0) first_acc = cyc + 1;
          beats++;
          done = 1;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_groups(int target);
    while (grps < target) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    rmode = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", G*W'(in_ready), 1);
    chk(!out0_valid, "R1 out0_valid after reset", G*W'(out0_valid), 0);
    chk(!out1_valid, "R1 out1_valid after reset", G*W'(out1_valid), 0);
  endtask

  task automatic t_latency;
    arm_lat = 1;
    first_acc = -1;
    first_out = -1;
    send_beats(126, 0, 1);
    wait_groups(GPF);
    chk(first_out - first_acc == 128, "R5 first input to first output",
        G*W'(first_out - first_acc), 128);
    arm_lat = 0;
  endtask

  task automatic t_stream;
    send_beats(3 * 126, 0, 1);
    wait_groups(4 * GPF);
    chk(grps == 4 * GPF, "R3 group count after stream", G*W'(grps), 4 * GPF);
  endtask

  task automatic t_stall;
    rmode = 1;
    send_beats(2 * 126, 1, 0);
    wait_groups(6 * GPF);
    rmode = 0;
    chk(grps == 6 * GPF, "R6 group count after stalls", G*W'(grps), 6 * GPF);
  endtask

  task automatic t_full;
    rmode = 2;
    send_beats(2 * 126, 0, 0);
    repeat (4) @(negedge clk);
    #1;
    chk(!in_ready, "R7 in_ready low with both halves held", G*W'(in_ready), 0);
    chk(out0_valid, "R7 stalled group presented", G*W'(out0_valid), 1);
    repeat (5) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = '1;
      #1;
      chk(!in_ready, "R7 offered beat refused", G*W'(in_ready), 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rmode = 0;
    wait_groups(8 * GPF);
    send_beats(126, 0, 0);
    wait_groups(9 * GPF);
    chk(grps == 9 * GPF, "R7 frame after refused beat", G*W'(grps), 9 * GPF);
  endtask

  initial begin
    t_reset;
    t_latency;
    t_stream;
    t_stall;
    t_full;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule